// File: doc/BRIEF.md
# Auto-Normalising Oscillator Sample Mixer

The mixer takes one signed 16-bit sample from each of 64 oscillators and merges them into a single signed 16-bit output sample on every clock. It sign-extends every sample and adds all of them into a wide sum. It then counts the oscillators that are running and uses that count to set the gain. An oscillator is running when its phase word is nonzero. The right shift applied to the sum therefore follows the number of live voices, so the peak output stays between half and full single-voice scale. The scale does not drop by a fixed factor of 64.

The mixer sits after a bank of numerically controlled oscillators. That bank presents all of its samples and phase words in parallel. The registered output feeds whatever converter or clock-domain stage follows. Both the oscillator bank and the stage after the mixer are outside this block.

Top module: `osc_mix_normalizer`

## Requirements
- R1: Lane i of the sample bus occupies bits [16i+15:16i] and is read as a two's-complement value. It is sign-extended to 24 bits before it is added.
- R2: All 64 extended samples are added into one 24-bit sum. Every lane contributes, active or not.
- R3: Oscillator i counts as active when its phase word, bits [16i+15:16i] of the phase bus, is nonzero. Any single set bit qualifies. A lane whose phase is zero still adds its sample to the sum but is not counted.
- R4: The shift equals the bit length of (active count − 1). The values are: 1 active → 0, 2 → 1, 3–4 → 2, 5–8 → 3, 9–16 → 4, 17–32 → 5, 33–64 → 6.
- R5: With no active oscillator the shift is 0 and the unscaled sum is passed on.
- R6: The shift is arithmetic. A negative sum stays negative and rounds toward minus infinity, so −99 shifted by 6 gives −2.
- R7: The output is registered. It shows the result for the inputs present at the previous rising clock edge and does not change between edges.
- R8: A synchronous active-high reset clears the output to 0.
- R9: The output is the low 16 bits of the shifted sum. Higher bits are dropped without saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| samples_i | input | 1024 | 64 packed signed 16-bit samples, lane i at [16i+15:16i] |
| phases_i | input | 1024 | 64 packed 16-bit phase words, lane i at [16i+15:16i] |
| sample_o | output | 16 | Registered, normalised signed output sample |

## Verification
The assertions assume that sample and phase buses hold known values at every rising edge outside reset, and that both buses change only between edges. The bench drives each new input set on the falling edge and reads the output one full edge later, so every value it checks comes from a single stable input set. Each table vector makes the first n lanes active with equal samples and leaves every other lane at zero in both buses. The directed cases then break that pattern on purpose: they use lanes with zero phase but nonzero samples, and sums that wrap past 16 bits.

// File: rtl/osc_mix_pkg.sv
package osc_mix_pkg;

    localparam int unsigned LANES      = 64;
    localparam int unsigned SAMPLE_W   = 16;
    localparam int unsigned PHASE_W    = 16;
    localparam int unsigned ACC_W      = 24;
    localparam int unsigned COUNT_W    = $clog2(LANES + 1);
    localparam int unsigned MAX_SHIFT  = $clog2(LANES);
    localparam int unsigned SHIFT_W    = $clog2(MAX_SHIFT + 1);

    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [COUNT_W-1:0]         count_t;
    typedef logic [SHIFT_W-1:0]         shift_t;

    // Mixer datapath bundle between the stages of the top module
    typedef struct packed {
        acc_t   total;
        count_t live;
        shift_t shamt;
    } mix_ctl_t;

    // Bit length of (n - 1); zero and one both map to 0
    function automatic shift_t gain_shift(input count_t n);
        count_t m;
        shift_t s;
        m = (n == '0) ? '0 : n - count_t'(1);
        s = '0;
        for (int b = 0; b < int'(COUNT_W); b++) begin
            if (m[b]) s = shift_t'(b + 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/osc_sum_tree.sv
module osc_sum_tree
    import osc_mix_pkg::*;
#(
    parameter int unsigned N  = LANES,
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned AW = ACC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N*SW-1:0]      samples_i,
    output logic signed [AW-1:0] sum_o
);

    localparam int unsigned DEPTH = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned LEAVES = 1 << DEPTH;

    // Heap-ordered adder tree: node k sums nodes 2k and 2k+1
    logic signed [AW-1:0] node [1:2*LEAVES-1];

    for (genvar i = 0; i < int'(LEAVES); i++) begin : g_leaf
        if (i < int'(N)) begin : g_used
            assign node[LEAVES+i] =
                {{(AW-SW){samples_i[i*SW+SW-1]}}, samples_i[i*SW +: SW]};
        end else begin : g_pad
            assign node[LEAVES+i] = '0;
        end
    end

    for (genvar k = 1; k < int'(LEAVES); k++) begin : g_node
        assign node[k] = node[2*k] + node[2*k+1];
    end

    assign sum_o = node[1];

    // R2: a bus of all-zero samples must give a zero total
    p_zero_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (samples_i == '0) |-> (sum_o == '0));

endmodule

// File: rtl/osc_active_count.sv
module osc_active_count
    import osc_mix_pkg::*;
#(
    parameter int unsigned N  = LANES,
    parameter int unsigned PW = PHASE_W,
    parameter int unsigned CW = COUNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N*PW-1:0]   phases_i,
    output logic [CW-1:0]     count_o
);

    logic [N-1:0] live;

    for (genvar i = 0; i < int'(N); i++) begin : g_live
        assign live[i] = |phases_i[i*PW +: PW];
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < int'(N); i++) begin
            count_o = count_o + CW'(live[i]);
        end
    end

    // R3: no nonzero phase word means no active oscillator
    p_idle_count_r3: assert property (@(posedge clk) disable iff (rst)
        (phases_i == '0) |-> (count_o == '0));

    // R3: the count never exceeds the number of lanes
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (count_o <= CW'(N)));

endmodule

// File: rtl/osc_gain_select.sv
module osc_gain_select
    import osc_mix_pkg::*;
#(
    parameter int unsigned CW  = COUNT_W,
    parameter int unsigned SHW = SHIFT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  count_i,
    output logic [SHW-1:0] shift_o
);

    always_comb shift_o = SHW'(gain_shift(count_t'(count_i)));

    // R4, R5: zero or one voice leaves the sum unscaled
    p_unity_gain_r4: assert property (@(posedge clk) disable iff (rst)
        (count_i <= CW'(1)) |-> (shift_o == '0));

    // R4: two voices halve the sum
    p_pair_halved_r4: assert property (@(posedge clk) disable iff (rst)
        (count_i == CW'(2)) |-> (shift_o == SHW'(1)));

endmodule

// File: rtl/osc_mix_normalizer.sv
module osc_mix_normalizer
    import osc_mix_pkg::*;
#(
    parameter int unsigned N  = LANES,
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned PW = PHASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N*SW-1:0]   samples_i,
    input  logic [N*PW-1:0]   phases_i,
    output logic [SW-1:0]     sample_o
);

    mix_ctl_t ctl;
    acc_t     scaled;

    osc_sum_tree #(.N(N), .SW(SW), .AW(ACC_W)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .samples_i (samples_i),
        .sum_o     (ctl.total)
    );

    osc_active_count #(.N(N), .PW(PW), .CW(COUNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .phases_i (phases_i),
        .count_o  (ctl.live)
    );

    osc_gain_select #(.CW(COUNT_W), .SHW(SHIFT_W)) u_gain (
        .clk     (clk),
        .rst     (rst),
        .count_i (ctl.live),
        .shift_o (ctl.shamt)
    );

    always_comb scaled = ctl.total >>> ctl.shamt;

    always_ff @(posedge clk) begin
        if (rst) sample_o <= '0;
        else     sample_o <= scaled[SW-1:0];
    end

    // R8: reset clears the output on the next edge
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (sample_o == '0));

    // R4, R9: a single voice passes the low bits of the sum unchanged
    p_single_voice_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.live == COUNT_W'(1)) |=> (sample_o == $past(ctl.total[SW-1:0])));

    // R5: no active voice passes the unscaled sum
    p_idle_unscaled_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.live == '0) |=> (sample_o == $past(ctl.total[SW-1:0])));

    // R6: a negative sum of -1 stays -1 under any shift
    p_sign_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.total == -acc_t'(1)) |=> (sample_o == {SW{1'b1}}));

endmodule

// File: tb/tb_osc_mix_normalizer.sv
module tb_osc_mix_normalizer;

    localparam int N  = 64;
    localparam int SW = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N*SW-1:0]  samples = '0;
    logic [N*SW-1:0]  phases  = '0;
    logic [SW-1:0]    sample_o;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    osc_mix_normalizer dut (
        .clk       (clk),
        .rst       (rst),
        .samples_i (samples),
        .phases_i  (phases),
        .sample_o  (sample_o)
    );

    typedef struct packed {
        logic [6:0]  n;
        logic [15:0] val;
        logic [15:0] expv;
    } vec_t;

    // First n lanes active with sample val; all others zero (R1, R2, R4, R6)
    localparam vec_t VECS [11] = '{
        '{7'd1,  16'd1000,  16'h03E8},
        '{7'd2,  16'd1000,  16'h03E8},
        '{7'd3,  16'd1000,  16'h02EE},
        '{7'd4,  16'hFC18,  16'hFC18},
        '{7'd5,  16'd4000,  16'h09C4},
        '{7'd8,  16'h8000,  16'h8000},
        '{7'd9,  16'h7FFF,  16'h47FF},
        '{7'd17, 16'd100,   16'h0035},
        '{7'd33, 16'hFFFD,  16'hFFFE},
        '{7'd64, 16'h7FFF,  16'h7FFF},
        '{7'd64, 16'h8000,  16'h8000}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic load_uniform(input int n, input logic [15:0] val);
        samples = '0;
        phases  = '0;
        for (int i = 0; i < N; i++) begin
            if (i < n) begin
                samples[i*SW +: SW] = val;
                phases[i*SW +: SW]  = (i == 0) ? 16'h8000 : 16'(i);
            end
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: output cleared by reset
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset state", sample_o, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: R1 R2 R4 R6
        foreach (VECS[v]) begin
            @(negedge clk);
            load_uniform(int'(VECS[v].n), VECS[v].val);
            settle();
            check($sformatf("R4 R1 R6 vector %0d (n=%0d)", v, VECS[v].n),
                  sample_o, VECS[v].expv);
        end

        // R5: no active lanes, unscaled sum 3*300 = 900
        @(negedge clk);
        load_uniform(0, 16'd0);
        for (int i = 0; i < 3; i++) samples[i*SW +: SW] = 16'd300;
        settle();
        check("R5 idle passes unscaled sum", sample_o, 16'd900);

        // R5: all zero gives zero
        @(negedge clk);
        load_uniform(0, 16'd0);
        settle();
        check("R5 all zero", sample_o, 16'h0000);

        // R3: two active + two zero-phase lanes, sum 400, count 2 -> 200
        @(negedge clk);
        load_uniform(2, 16'd100);
        samples[10*SW +: SW] = 16'd100;
        samples[40*SW +: SW] = 16'd100;
        settle();
        check("R3 zero phase not counted", sample_o, 16'd200);

        // R3: only the top phase bit of lane 63 set -> one active, sum -5
        @(negedge clk);
        load_uniform(0, 16'd0);
        phases[63*SW +: SW]  = 16'h8000;
        samples[63*SW +: SW] = 16'hFFFB;
        samples[5*SW +: SW]  = 16'd0;
        settle();
        check("R3 single high phase bit", sample_o, 16'hFFFB);

        // R9: wrap, 3*20000 = 60000 unscaled -> 0xEA60
        @(negedge clk);
        load_uniform(0, 16'd0);
        for (int i = 0; i < 3; i++) samples[i*SW +: SW] = 16'd20000;
        settle();
        check("R9 truncation to 16 bits", sample_o, 16'hEA60);

        // R7: hold between edges, update after the edge
        @(negedge clk);
        load_uniform(1, 16'd1234);
        #1;
        check("R7 output held before edge", sample_o, 16'hEA60);
        settle();
        check("R7 output updated after edge", sample_o, 16'd1234);

        // R8: reset mid-run with live inputs
        @(negedge clk);
        rst = 1'b1;
        settle();
        check("R8 reset during operation", sample_o, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        settle();
        check("R8 resumes after reset", sample_o, 16'd1234);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule